// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Controller

This block collects interrupt requests from a row of source cells and resolves them by position in a serial acknowledge chain. Every cell holds one pending flag. The pending flags are OR-ed onto a single shared request line toward the processor.

When the processor is ready, the processor-side acknowledge generator asserts an acknowledge pulse. The pulse enters the cell at position 0, which has the highest priority, and travels toward position N-1. A cell that is pending when the pulse reaches it keeps the pulse and drives its own vector onto the vector bus. A cell that is idle passes the pulse on unchanged. The generator latches whatever is on the bus as the identity of the service routine. If no cell takes the pulse, the bus reads zero.

The generator is a three-state machine:
- IDLE waits for the request line and `cpu_ready`. On both it moves to ACK.
- ACK drives the acknowledge for exactly one cycle and samples the bus. It always moves to VECTOR.
- VECTOR presents the latched vector with a one-cycle valid strobe. It always returns to IDLE.

Top module: `irq_daisy_chain`

## Requirements
- R1: `irq_line` is high in a cycle exactly when at least one bit of `pend_q` is high.
- R2: A high `src_raise[i]` sets `pend_q[i]` at the next clock edge. This holds even if the same cell is being read or cancelled in that cycle.
- R3: From IDLE the generator moves to ACK when `irq_line` and `cpu_ready` are both high. `intack` is high only in ACK, for exactly one cycle per acknowledge.
- R4: Cell 0 is the highest priority. The acknowledge is taken by the lowest-index pending cell. Cell i supplies the vector `VEC_BASE + i*VEC_STEP`, truncated to `VW` bits.
- R5: Cells after the taker see no acknowledge. Their pending bits are unchanged by the acknowledge.
- R6: The taker's pending bit clears at the edge that ends the ACK cycle, unless R2 sets it again.
- R7: The bus value is latched at the end of ACK. In the following cycle (state VECTOR), `vec_valid` is high and `vec_out` carries it. The generator then returns to IDLE.
- R8: If no cell is pending during ACK, the latched vector is zero.
- R9: At most one cell drives the vector bus in any cycle.
- R10: A high `src_cancel[i]` without `src_raise[i]` clears `pend_q[i]` at the next edge.
- R11: After reset, `pend_q`, `irq_line`, `intack`, `vec_valid` and `vec_out` are all zero, and the generator is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_raise | input | N | Per-source request pulse; sets pending |
| src_cancel | input | N | Per-source withdrawal; clears pending |
| cpu_ready | input | 1 | Processor can accept an interrupt |
| irq_line | output | 1 | Shared interrupt request |
| intack | output | 1 | Acknowledge pulse entering cell 0 |
| vec_valid | output | 1 | Latched vector valid (state VECTOR) |
| vec_out | output | VW | Latched vector |
| pend_q | output | N | Pending flags of all cells |

## Verification
The bench builds the block with N=5, VW=7, VEC_BASE=0x11 and VEC_STEP=5. This gives five distinct non-zero vectors, so a wrong taker index shows up directly as a wrong vector. With five cells, simultaneous requests reach the tail of the chain often enough to test pass-through at every position. Random withdrawals made in the cycle before an acknowledge reach the empty-chain case, which must return the zero vector.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACK    = 2'd1,
        ST_VECTOR = 2'd2
    } ack_state_t;
endpackage

// File: rtl/irq_chain_cell.sv
module irq_chain_cell #(
    parameter int            VW  = 8,
    parameter logic [VW-1:0] VEC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raise,
    input  logic          cancel,
    input  logic          ack_in,
    output logic          ack_out,
    output logic          taken,
    output logic [VW-1:0] drive,
    output logic          pending
);
    // Acknowledge is kept by a pending cell, passed by an idle one.
    always_comb begin
        taken   = ack_in & pending;
        ack_out = ack_in & ~pending;
        drive   = taken ? VEC : '0;
    end

    // A new request outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (raise)
            pending <= 1'b1;
        else if (taken || cancel)
            pending <= 1'b0;
    end

    // R2
    raise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> pending);
    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && pending && !raise) |=> !pending);
    // R10
    cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel && !raise) |=> !pending);
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_chain_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_line,
    input  logic          cpu_ready,
    input  logic [VW-1:0] vec_bus,
    output logic          intack,
    output logic          vec_valid,
    output logic [VW-1:0] vec_out
);
    ack_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (irq_line && cpu_ready) state_d = ST_ACK;
            ST_ACK:    state_d = ST_VECTOR;
            ST_VECTOR: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        intack    = (state_q == ST_ACK);
        vec_valid = (state_q == ST_VECTOR);
    end

    // Vector is sampled in the same cycle the acknowledge is driven.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_out <= '0;
        else if (state_q == ST_ACK)
            vec_out <= vec_bus;
    end

    // R3
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intack |=> !intack);
    // R7
    ack_to_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intack |=> vec_valid);
    // R7
    vector_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> (!vec_valid && !intack));
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
    parameter int N        = 6,
    parameter int VW       = 8,
    parameter int VEC_BASE = 32,
    parameter int VEC_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  src_raise,
    input  logic [N-1:0]  src_cancel,
    input  logic          cpu_ready,
    output logic          irq_line,
    output logic          intack,
    output logic          vec_valid,
    output logic [VW-1:0] vec_out,
    output logic [N-1:0]  pend_q
);
    logic [N:0]            ack_chain;
    logic [N-1:0]          taken;
    logic [N-1:0][VW-1:0]  drive;
    logic [VW-1:0]         vec_bus;

    assign ack_chain[0] = intack;

    for (genvar i = 0; i < N; i++) begin : g_cell
        localparam logic [VW-1:0] CELL_VEC = VW'(VEC_BASE + i * VEC_STEP);
        irq_chain_cell #(.VW(VW), .VEC(CELL_VEC)) cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .raise   (src_raise[i]),
            .cancel  (src_cancel[i]),
            .ack_in  (ack_chain[i]),
            .ack_out (ack_chain[i+1]),
            .taken   (taken[i]),
            .drive   (drive[i]),
            .pending (pend_q[i])
        );
    end

    // Wired-OR bus: idle cells drive zero, so an empty chain reads zero.
    always_comb begin
        vec_bus = '0;
        for (int i = 0; i < N; i++) vec_bus = vec_bus | drive[i];
    end

    assign irq_line = |pend_q;

    irq_ack_fsm #(.VW(VW)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_line  (irq_line),
        .cpu_ready (cpu_ready),
        .vec_bus   (vec_bus),
        .intack    (intack),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    // R9
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(taken));
    // R8
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intack && !irq_line) |=> (vec_valid && vec_out == '0));
    // R5
    tail_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intack && irq_line) |-> !ack_chain[N]);
endmodule

// File: tb/irq_daisy_chain_tb_top.sv
module irq_daisy_chain_tb_top;
    localparam int N = 5;
    localparam int VW = 7;
    localparam int VEC_BASE = 17;
    localparam int VEC_STEP = 5;
    localparam int WATCHDOG_NS = 400000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_raise = '0;
    logic [N-1:0]  src_cancel = '0;
    logic          cpu_ready = 1'b0;
    logic          irq_line, intack, vec_valid;
    logic [VW-1:0] vec_out;
    logic [N-1:0]  pend_q;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // model state: 0 idle, 1 ack, 2 vector
    int           m_st = 0;
    logic [N-1:0] m_pend = '0;
    logic [VW-1:0] m_vec = '0;

    always #2 clk = ~clk;

    irq_daisy_chain #(.N(N), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_raise(src_raise), .src_cancel(src_cancel),
        .cpu_ready(cpu_ready), .irq_line(irq_line), .intack(intack),
        .vec_valid(vec_valid), .vec_out(vec_out), .pend_q(pend_q)
    );

    function automatic logic [VW-1:0] vec_of(int idx);
        return VW'(VEC_BASE + idx * VEC_STEP);
    endfunction

    function automatic logic [N-1:0] first_set(logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
        return '0;
    endfunction

    function automatic logic [VW-1:0] vec_for(logic [N-1:0] onehot);
        for (int i = 0; i < N; i++) if (onehot[i]) return vec_of(i);
        return '0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R1 irq_line", 32'(irq_line), 32'(|m_pend));
        chk("R2/R6/R10 pend_q", 32'(pend_q), 32'(m_pend));
        chk("R3 intack", 32'(intack), 32'(m_st == 1));
        chk("R7 vec_valid", 32'(vec_valid), 32'(m_st == 2));
        if (m_st == 2) chk("R4/R8 vec_out", 32'(vec_out), 32'(m_vec));
    endtask

    // One cycle: check at negedge, drive, predict, advance at posedge.
    task automatic step(logic [N-1:0] r, logic [N-1:0] c, logic rdy);
        logic [N-1:0] tk;
        logic [N-1:0] p_n;
        logic [VW-1:0] v_n;
        int s_n;
        @(negedge clk);
        compare();
        src_raise = r; src_cancel = c; cpu_ready = rdy;
        tk  = (m_st == 1) ? first_set(m_pend) : '0;
        p_n = r | (m_pend & ~tk & ~c);
        v_n = (m_st == 1) ? vec_for(tk) : m_vec;
        case (m_st)
            0:       s_n = (|m_pend && rdy) ? 1 : 0;
            1:       s_n = 2;
            default: s_n = 0;
        endcase
        @(posedge clk);
        m_pend = p_n; m_vec = v_n; m_st = s_n;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(WATCHDOG_NS);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11 pend_q", 32'(pend_q), 0);
        chk("R11 irq_line", 32'(irq_line), 0);
        chk("R11 intack", 32'(intack), 0);
        chk("R11 vec_valid", 32'(vec_valid), 0);
        chk("R11 vec_out", 32'(vec_out), 0);
        rst_n = 1'b1;
        @(posedge clk);

        // R4/R5: all cells at once, served in position order
        step('1, '0, 1'b0);
        step('0, '0, 1'b0);
        repeat (16) step('0, '0, 1'b1);

        // R2: raise on the taker during ACK keeps it pending
        step(N'(5'b00100), '0, 1'b1);
        step('0, '0, 1'b1);                // IDLE -> ACK
        step(N'(5'b00100), '0, 1'b1);      // ACK: re-raise same cell
        repeat (6) step('0, '0, 1'b1);

        // R8: withdraw in the IDLE cycle that launches ACK -> empty chain
        step(N'(5'b01000), '0, 1'b0);
        step('0, '0, 1'b0);
        step('0, N'(5'b01000), 1'b1);      // ACK next with no taker
        repeat (4) step('0, '0, 1'b1);

        // R10: cancel while processor is not ready
        step(N'(5'b10001), '0, 1'b0);
        step('0, N'(5'b00001), 1'b0);
        repeat (6) step('0, '0, 1'b1);

        // Constrained random
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] r, c;
            r = '0; c = '0;
            for (int i = 0; i < N; i++) begin
                r[i] = ($urandom_range(0, 9) == 0);
                c[i] = ($urandom_range(0, 24) == 0);
            end
            step(r, c, ($urandom_range(0, 3) != 0));
        end
        repeat (12) step('0, '0, 1'b1);
        @(negedge clk);
        compare();
        finish_run();
    end
endmodule